// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block collects up to eight interrupt request lines, ranks them by a fixed priority in which line 0 is the most urgent, and tells a processor when a request is waiting that outranks everything currently being serviced. Software reaches it through two byte-wide register addresses. The command address starts configuration, issues end-of-interrupt, and picks which status register it reads back. The data address carries the configuration words and, once setup is complete, the per-line mask.

Setup is a short ordered sequence. A command write with bit 4 set opens it and says which of the later words will follow. The data address then takes the vector base, an optional cascade word and an optional mode word, in that order. When the processor acknowledges, the winning line moves into the in-service set and a vector is presented. Its upper five bits come from the base and its lower three bits are the line number.

Top module: `irq_ctl8`

## Requirements
- R1: After reset, cfg_ready and int_req are 0, vec_out is 0x00, the data address reads 0xFF (all lines masked) and the command address reads 0x00.
- R2: A command-address write with bit 4 set restarts setup. In the next cycle cfg_ready is 0, the mask reads 0x00, and the request register, the in-service register and the edge history are cleared. Command reads are switched back to the request register.
- R3: In that starting byte, bit 0 = 1 means a mode word will follow and bit 1 = 1 means the cascade word is skipped. The data writes that follow are taken in order: base, then cascade (unless skipped), then mode (if announced). cfg_ready rises in the cycle after the last expected write, and cascade_cfg holds the most recently accepted cascade word.
- R4: Once cfg_ready is 1, a data-address write loads the mask and a data-address read returns it. A mask bit of 1 keeps its line from raising int_req.
- R5: In edge mode (starting byte bit 3 = 0), a rising edge on a line sets its request bit one clock later. The bit stays set until that line is acknowledged, and a line that stays high does not request again.
- R6: In level mode (starting byte bit 3 = 1), each request bit copies its input line with a latency of one clock.
- R7: int_req is 1 only when cfg_ready is 1 and some unmasked request is on a line with a lower number than every in-service line.
- R8: An int_ack while int_req is 1 loads vec_out with {base[7:3], winning line number}, sets that line's in-service bit and clears its edge-mode request bit, all on the next clock.
- R9: When the mode word's bit 1 is set (automatic end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R10: Writing 0x20 to the command address while cfg_ready is 1 clears the lowest-numbered set in-service bit.
- R11: After a command write of 0x0A, command-address reads return the request register. After 0x0B, they return the in-service register.
- R12: An int_ack while int_req is 0 changes neither vec_out nor the in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 command, 1 data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected address, combinational |
| irq_in | input | 8 | Interrupt request lines |
| int_ack | input | 1 | Processor acknowledge strobe |
| int_req | output | 1 | Interrupt pending toward the processor |
| vec_out | output | 8 | Vector of the most recently acknowledged line |
| cfg_ready | output | 1 | Setup sequence complete |
| cascade_cfg | output | 8 | Stored cascade word |

## Verification
The hardest state to reach is nested service, where a lower-priority request waits behind an in-service line and a higher-priority one pre-empts it. The stimulus builds this from the ports alone. It raises a mid-priority line and acknowledges it, then adds a lower-priority line, then a higher one. It then retires the in-service lines one end-of-interrupt at a time and checks that the blocked request surfaces only when nothing above it remains in service. A second restart switches to level mode with the cascade word skipped and automatic end-of-interrupt. A third leaves out the mode word, so every branch of the setup sequence is driven.

// File: rtl/irq_ctl8_pkg.sv
// Package: shared state type and command encodings for the interrupt controller.
// Assumes byte-wide register writes.
package irq_ctl8_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_BASE,
        SQ_CASC,
        SQ_MODE,
        SQ_READY
    } sq_state_t;

    localparam logic [7:0] CMD_EOI     = 8'h20;
    localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
    localparam logic [7:0] CMD_SEL_SRV = 8'h0B;

    localparam int BIT_START    = 4;
    localparam int BIT_HAS_MODE = 0;
    localparam int BIT_NO_CASC  = 1;
    localparam int BIT_LEVEL    = 3;
    localparam int BIT_AUTO_EOI = 1;

endpackage

// File: rtl/irq_ctl8_seq.sv
// Module: irq_ctl8_seq
// Decodes register writes. It steps through the setup word sequence, holds the
// configuration and the mask, and emits single-cycle start and end-of-interrupt strobes.
// Assumes one write per strobe cycle and NL <= DW.
module irq_ctl8_seq
    import irq_ctl8_pkg::*;
#(
    parameter int DW = 8,
    parameter int NL = 8,
    localparam int IW = $clog2(NL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    output logic             start,
    output logic             eoi,
    output logic             ready,
    output logic [DW-IW-1:0] base_hi,
    output logic [DW-1:0]    cascade,
    output logic             level_mode,
    output logic             auto_eoi,
    output logic [NL-1:0]    mask,
    output logic             sel_srv
);

    sq_state_t state_q;
    logic      has_mode_q;
    logic      no_casc_q;
    logic      cmd_op;
    logic      data_wr;

    // Decode the kind of write present this cycle.
    always_comb begin
        start   = wr && !addr && wdata[BIT_START];
        cmd_op  = wr && !addr && !wdata[BIT_START] && (state_q == SQ_READY);
        eoi     = cmd_op && (wdata == CMD_EOI);
        data_wr = wr && addr;
        ready   = (state_q == SQ_READY);
    end

    // Setup sequence, configuration storage, mask and read-back select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            has_mode_q <= 1'b0;
            no_casc_q  <= 1'b0;
            level_mode <= 1'b0;
            auto_eoi   <= 1'b0;
            base_hi    <= '0;
            cascade    <= '0;
            mask       <= '1;
            sel_srv    <= 1'b0;
        end else if (start) begin
            state_q    <= SQ_BASE;
            has_mode_q <= wdata[BIT_HAS_MODE];
            no_casc_q  <= wdata[BIT_NO_CASC];
            level_mode <= wdata[BIT_LEVEL];
            auto_eoi   <= 1'b0;
            mask       <= '0;
            sel_srv    <= 1'b0;
        end else if (data_wr) begin
            case (state_q)
                SQ_BASE: begin
                    base_hi <= wdata[DW-1:IW];
                    if (!no_casc_q)     state_q <= SQ_CASC;
                    else if (has_mode_q) state_q <= SQ_MODE;
                    else                state_q <= SQ_READY;
                end
                SQ_CASC: begin
                    cascade <= wdata;
                    state_q <= has_mode_q ? SQ_MODE : SQ_READY;
                end
                SQ_MODE: begin
                    auto_eoi <= wdata[BIT_AUTO_EOI];
                    state_q  <= SQ_READY;
                end
                SQ_READY: mask <= wdata[NL-1:0];
                default: ;
            endcase
        end else if (cmd_op) begin
            if (wdata == CMD_SEL_REQ)      sel_srv <= 1'b0;
            else if (wdata == CMD_SEL_SRV) sel_srv <= 1'b1;
        end
    end

endmodule

// File: rtl/irq_ctl8_lsb.sv
// Module: irq_ctl8_lsb
// Finds the lowest set bit of a vector and returns it one-hot and as an index.
// Purely combinational; assumes NL >= 2.
module irq_ctl8_lsb #(
    parameter int NL = 8,
    localparam int IW = $clog2(NL)
) (
    input  logic [NL-1:0] vec,
    output logic [NL-1:0] onehot,
    output logic [IW-1:0] idx,
    output logic          any
);

    // Isolate the lowest set bit and encode its position.
    always_comb begin
        onehot = vec & (-vec);
        any    = |vec;
        idx    = '0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/irq_ctl8_state.sv
// Module: irq_ctl8_state
// Holds the request register, the in-service register and the edge history.
// Assumes the take and eoi one-hot inputs have at most one bit set.
module irq_ctl8_state #(
    parameter int NL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] irq_in,
    input  logic          start,
    input  logic          level_mode,
    input  logic          auto_eoi,
    input  logic          take,
    input  logic [NL-1:0] win_oh,
    input  logic          eoi,
    input  logic [NL-1:0] srv_low_oh,
    output logic [NL-1:0] irr_q,
    output logic [NL-1:0] isr_q
);

    logic [NL-1:0] prev_q;
    logic [NL-1:0] take_oh;
    logic [NL-1:0] clr_oh;

    // Gate the acknowledge and end-of-interrupt bit selections.
    always_comb begin
        take_oh = take ? win_oh : '0;
        clr_oh  = eoi ? srv_low_oh : '0;
    end

    // Capture requests by edge or level; move acknowledged lines to in-service.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            prev_q <= '0;
            irr_q  <= '0;
            isr_q  <= '0;
        end else begin
            prev_q <= irq_in;
            irr_q  <= level_mode ? irq_in : ((irr_q & ~take_oh) | (irq_in & ~prev_q));
            isr_q  <= (isr_q & ~clr_oh) | (auto_eoi ? '0 : take_oh);
        end
    end

endmodule

// File: rtl/irq_ctl8.sv
// Module: irq_ctl8 (top)
// Eight-line interrupt controller with a command address and a data address.
// It ranks requests by fixed priority, with line 0 the most urgent, and forms the
// vector on acknowledge. Assumes the reset is synchronous and active-low.
module irq_ctl8
    import irq_ctl8_pkg::*;
#(
    parameter int DW = 8,
    parameter int NL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [NL-1:0] irq_in,
    input  logic          int_ack,
    output logic          int_req,
    output logic [DW-1:0] vec_out,
    output logic          cfg_ready,
    output logic [DW-1:0] cascade_cfg
);

    localparam int IW = $clog2(NL);

    logic             start, eoi, level_mode, auto_eoi, sel_srv, take;
    logic [DW-IW-1:0] base_hi;
    logic [NL-1:0]    mask_q, irr_q, srv_q, pending;
    logic [NL-1:0]    win_oh, srv_oh;
    logic [IW-1:0]    win_idx, srv_idx;
    logic             pend_any, srv_any;

    irq_ctl8_seq #(.DW(DW), .NL(NL)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .start(start), .eoi(eoi), .ready(cfg_ready), .base_hi(base_hi),
        .cascade(cascade_cfg), .level_mode(level_mode), .auto_eoi(auto_eoi),
        .mask(mask_q), .sel_srv(sel_srv)
    );

    // Unmasked requests count only after setup.
    always_comb pending = irr_q & ~mask_q & {NL{cfg_ready}};

    irq_ctl8_lsb #(.NL(NL)) u_pend (.vec(pending), .onehot(win_oh), .idx(win_idx), .any(pend_any));
    irq_ctl8_lsb #(.NL(NL)) u_srv  (.vec(srv_q),   .onehot(srv_oh), .idx(srv_idx), .any(srv_any));

    irq_ctl8_state #(.NL(NL)) u_state (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .start(start),
        .level_mode(level_mode), .auto_eoi(auto_eoi), .take(take), .win_oh(win_oh),
        .eoi(eoi), .srv_low_oh(srv_oh), .irr_q(irr_q), .isr_q(srv_q)
    );

    // Request only when the winner outranks every in-service line.
    always_comb begin
        int_req = pend_any && (!srv_any || (win_idx < srv_idx));
        take    = int_ack && int_req;
    end

    // Latch the vector of the line being acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)    vec_out <= '0;
        else if (take) vec_out <= {base_hi, win_idx};
    end

    // Read-back multiplexer for the two addresses.
    always_comb begin
        if (reg_addr)     reg_rdata = DW'(mask_q);
        else if (sel_srv) reg_rdata = DW'(srv_q);
        else              reg_rdata = DW'(irr_q);
    end

endmodule

// File: rtl/irq_ctl8_chk.sv
// Module: irq_ctl8_chk
// Assertion checker attached to irq_ctl8. Sees the ports plus the in-service
// register and the automatic end-of-interrupt setting.
module irq_ctl8_chk #(
    parameter int DW = 8,
    parameter int NL = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_addr,
    input logic          reg_wr,
    input logic [DW-1:0] reg_wdata,
    input logic          int_ack,
    input logic          int_req,
    input logic [DW-1:0] vec_out,
    input logic          cfg_ready,
    input logic [NL-1:0] srv_q,
    input logic          auto_eoi
);

    logic start_wr, eoi_wr;
    always_comb begin
        start_wr = reg_wr && !reg_addr && reg_wdata[4];
        eoi_wr   = reg_wr && !reg_addr && (reg_wdata == 8'h20) && cfg_ready;
    end

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (!cfg_ready && srv_q == '0));

    a_r3_ready_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_ready) |-> $past(reg_wr && reg_addr));

    a_r7_req_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> cfg_ready);

    a_r8_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req && !auto_eoi && !reg_wr) |=> (srv_q != '0));

    a_r9_auto_keeps_service: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req && auto_eoi && !reg_wr) |=> $stable(srv_q));

    a_r10_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && srv_q != '0 && !int_ack) |=> ($countones(srv_q) + 1 == $past($countones(srv_q))));

    a_r12_vec_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_ack && int_req) |=> $stable(vec_out));

endmodule

bind irq_ctl8 irq_ctl8_chk #(.DW(DW), .NL(NL)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .int_ack(int_ack), .int_req(int_req),
    .vec_out(vec_out), .cfg_ready(cfg_ready), .srv_q(srv_q), .auto_eoi(auto_eoi)
);

// File: tb/irq_ctl8_tb.sv
`timescale 1ns/1ps
module irq_ctl8_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       int_ack = 1'b0;
    logic       int_req;
    logic [7:0] vec_out;
    logic       cfg_ready;
    logic [7:0] cascade_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_ctl8 u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .int_ack(int_ack), .int_req(int_req), .vec_out(vec_out),
        .cfg_ready(cfg_ready), .cascade_cfg(cascade_cfg)
    );

    // ---------------- behavioural reference model ----------------
    int       m_st;     // 0 idle, 1 base, 2 cascade, 3 mode, 4 ready
    bit [7:0] m_mask, m_irr, m_isr, m_prev, m_base, m_cas, m_vec;
    bit       m_has_mode, m_no_cas, m_level, m_auto, m_sel;

    function automatic bit m_req();
        for (int i = 0; i < 8; i++) begin
            if (m_isr[i]) return 1'b0;
            if (m_irr[i] && !m_mask[i]) return (m_st == 4);
        end
        return 1'b0;
    endfunction

    function automatic int m_win();
        for (int i = 0; i < 8; i++) if (m_irr[i] && !m_mask[i]) return i;
        return 0;
    endfunction

    function automatic bit [7:0] m_low_isr();
        for (int i = 0; i < 8; i++) if (m_isr[i]) return 8'(1 << i);
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_mask = 8'hFF; m_irr = 0; m_isr = 0; m_prev = 0;
            m_base = 0; m_cas = 0; m_vec = 0; m_has_mode = 0; m_no_cas = 0;
            m_level = 0; m_auto = 0; m_sel = 0;
        end else begin
            bit       req;
            int       w;
            bit       take;
            bit [7:0] take_oh, clr_oh;
            req = m_req();
            w = m_win();
            take = int_ack && req;
            take_oh = take ? 8'(1 << w) : 8'h00;
            if (take) m_vec = {m_base[7:3], 3'(w)};
            if (reg_wr && !reg_addr && reg_wdata[4]) begin
                m_st = 1; m_has_mode = reg_wdata[0]; m_no_cas = reg_wdata[1];
                m_level = reg_wdata[3]; m_auto = 0; m_mask = 0; m_sel = 0;
                m_irr = 0; m_isr = 0; m_prev = 0;
            end else begin
                clr_oh = (reg_wr && !reg_addr && reg_wdata == 8'h20 && m_st == 4) ? m_low_isr() : 8'h00;
                m_irr = m_level ? irq_in : ((m_irr & ~take_oh) | (irq_in & ~m_prev));
                m_prev = irq_in;
                m_isr = (m_isr & ~clr_oh) | (m_auto ? 8'h00 : take_oh);
                if (reg_wr && reg_addr) begin
                    case (m_st)
                        1: begin m_base = reg_wdata; m_st = !m_no_cas ? 2 : (m_has_mode ? 3 : 4); end
                        2: begin m_cas = reg_wdata; m_st = m_has_mode ? 3 : 4; end
                        3: begin m_auto = reg_wdata[1]; m_st = 4; end
                        4: m_mask = reg_wdata;
                        default: ;
                    endcase
                end else if (reg_wr && !reg_addr && m_st == 4) begin
                    if (reg_wdata == 8'h0A) m_sel = 0;
                    else if (reg_wdata == 8'h0B) m_sel = 1;
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 int_req vs model", int'(int_req), int'(m_req()));
            chk("R8 vec_out vs model", int'(vec_out), int'(m_vec));
            chk("R3 cfg_ready vs model", int'(cfg_ready), int'(m_st == 4));
            chk("R3 cascade_cfg vs model", int'(cascade_cfg), int'(m_cas));
            chk("R11 reg_rdata vs model", int'(reg_rdata),
                int'(reg_addr ? m_mask : (m_sel ? m_isr : m_irr)));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(bit a, bit [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic ack();
        int_ack = 1;
        @(posedge clk); #1;
        int_ack = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic rd(bit a, int exp, string tag);
        reg_addr = a; #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1 cfg_ready", int'(cfg_ready), 0);
        chk("R1 int_req", int'(int_req), 0);
        chk("R1 vec_out", int'(vec_out), 8'h00);
        rd(1, 8'hFF, "R1 mask read");
        rd(0, 8'h00, "R1 command read");

        // R3 full sequence: cascade plus mode word, edge mode
        wr(0, 8'h11);
        wr(1, 8'h40);
        wr(1, 8'h04);
        chk("R3 not ready before mode word", int'(cfg_ready), 0);
        wr(1, 8'h01);
        chk("R3 ready after mode word", int'(cfg_ready), 1);
        chk("R3 cascade stored", int'(cascade_cfg), 8'h04);
        rd(1, 8'h00, "R2 mask cleared");

        // R5 edge capture, R8 vector
        irq_in = 8'h20; idle(1);
        chk("R5 edge raises request", int'(int_req), 1);
        ack();
        chk("R8 vector line 5", int'(vec_out), 8'h45);
        chk("R5 held line no retrigger", int'(int_req), 0);
        wr(0, 8'h0B);
        rd(0, 8'h20, "R11 in-service read");

        // R7 nesting
        irq_in = 8'hA0; idle(1);
        chk("R7 lower priority blocked", int'(int_req), 0);
        irq_in = 8'hA8; idle(1);
        chk("R7 higher priority preempts", int'(int_req), 1);
        ack();
        chk("R8 vector line 3", int'(vec_out), 8'h43);
        rd(0, 8'h28, "R8 nested in-service");
        wr(0, 8'h20);
        rd(0, 8'h20, "R10 eoi clears line 3");
        chk("R7 line 7 still blocked", int'(int_req), 0);
        wr(0, 8'h20);
        chk("R10 line 7 released", int'(int_req), 1);
        ack();
        chk("R8 vector line 7", int'(vec_out), 8'h47);
        wr(0, 8'h20);

        // R12 ack without request
        chk("R12 no request", int'(int_req), 0);
        ack();
        chk("R12 vec unchanged", int'(vec_out), 8'h47);
        rd(0, 8'h00, "R12 in-service unchanged");

        // R11 request read-back
        wr(0, 8'h0A);
        irq_in = 8'h00; idle(1);
        irq_in = 8'h02; idle(1);
        rd(0, 8'h02, "R11 request read");

        // R4 mask
        wr(1, 8'h02);
        chk("R4 masked line", int'(int_req), 0);
        rd(1, 8'h02, "R4 mask read");
        wr(1, 8'h00);
        chk("R4 unmasked line", int'(int_req), 1);
        wr(1, 8'hFF);
        chk("R4 all masked", int'(int_req), 0);

        // R2 restart: level, no cascade, auto end-of-interrupt
        wr(0, 8'h1B);
        chk("R2 ready cleared", int'(cfg_ready), 0);
        chk("R2 int_req low", int'(int_req), 0);
        rd(1, 8'h00, "R2 mask cleared on restart");
        wr(1, 8'h68);
        chk("R3 cascade skipped, awaiting mode", int'(cfg_ready), 0);
        wr(1, 8'h03);
        chk("R3 ready single mode", int'(cfg_ready), 1);
        chk("R3 cascade kept", int'(cascade_cfg), 8'h04);
        chk("R6 level request", int'(int_req), 1);
        ack();
        chk("R8 vector base 0x68 line 1", int'(vec_out), 8'h69);
        wr(0, 8'h0B);
        rd(0, 8'h00, "R9 auto eoi keeps in-service empty");
        chk("R6 level still asserted", int'(int_req), 1);
        irq_in = 8'h00; idle(1);
        chk("R6 level follows drop", int'(int_req), 0);

        // R3 no mode word
        wr(0, 8'h10);
        wr(1, 8'h20);
        chk("R3 waiting for cascade", int'(cfg_ready), 0);
        wr(1, 8'h02);
        chk("R3 ready without mode word", int'(cfg_ready), 1);
        chk("R3 new cascade", int'(cascade_cfg), 8'h02);

        idle(2);
        finish_run();
    end

endmodule